// File: doc/BRIEF.md
# Command/Data Stream Sequencer

The sequencer takes 17-bit words from an input stream. A word with its top bit set is a command; a word with its top bit clear is a data word. A command picks a working mode, and that mode stays in force. Every data word that follows is then carried out under the mode, for as long as the software needs, without the command being sent again. This lets long runs of pin updates, bus transfers or register loads go through at full rate once a single command has set them up.

The modes cover several kinds of work:
- driving, sampling and steering eight general pins;
- passing words to a peripheral engine through a valid/ready handshake;
- timed waits;
- two PWM period updates;
- a sixteen-entry configuration file reached through an auto-incrementing pointer.

Results from pin samples, peripheral reads and register reads leave on a valid/ready output stream. Three configuration entries drive the pin output-enable, pin open-drain and pull-up controls directly.

Back-pressure works as follows. The input is accepted only while `in_ready` is high. `in_ready` is low in each of these cases:
- a result is waiting on the output;
- a peripheral transfer is open;
- a delay is running;
- a register burst is running;
- the sequencer is halted.

A pending result holds `out_valid` high with `out_data` stable until `out_ready` is seen.

Top module: `cmdseq_top`

## Requirements
- R1: Bit 16 of `in_word` set marks a command whose opcode is bits 7:0; bit 16 clear marks a data word in bits 15:0. A data word that arrives before any command is discarded with no effect on any output.
- R2: After opcode 0x00, each data word produces a one-cycle `pin_wr_valid` with `pin_wr_data` equal to its bits 7:0, one cycle after acceptance. Opcode 0x02 does the same on `pin_dir_valid`/`pin_dir_data`. The mode persists across any number of data words.
- R3: After opcode 0x01, each data word pushes `{8'h00, pin_in}` to the output stream, with `pin_in` sampled in the acceptance cycle.
- R4: After opcode 0x03 (write) or 0x04 (read), each data word is presented on `per_data` with `per_read` set for reads. `per_valid` stays high with `per_data` stable until `per_ready`. For reads, `per_rdata` in the handshake cycle is pushed to the output. No new word is accepted until the handshake completes.
- R5: After opcode 0x05, a data word N holds `in_ready` low for exactly N cycles following the acceptance cycle. N = 0 adds no wait.
- R6: After opcode 0x06 or 0x07, each data word produces a one-cycle `pwm_on_valid` or `pwm_off_valid` respectively, with `pwm_period` equal to the word.
- R7: After opcode 0x0B, each data word loads the register pointer from its bits 3:0.
- R8: After opcode 0x0C, each data word is written to the entry at the pointer, and the pointer then advances by one, wrapping from 15 to 0.
- R9: After opcode 0x0D, a data word's bits 4:0 give a count C. C entries are pushed to the output starting at the pointer, which advances (with wrap) once per entry. C = 0 pushes nothing.
- R10: `pin_oe` mirrors entry 0 bits 7:0, `pin_od` mirrors entry 1 bits 7:0, and `pullup_en` mirrors entry 2 bit 0. All entries reset to zero.
- R11: Opcodes 0x09 and 0x0A take no data word. They produce a one-cycle `la_start` or `la_stop` respectively and set the mode to idle, so later data words are discarded.
- R12: Opcode 0x0F takes no data word. It raises `halted` and holds `in_ready` low until a `resume` pulse, after which processing continues in idle mode.
- R13: Every other opcode (including 0x08 and 0x0E) sets the idle mode; following data words are discarded.
- R14: `out_valid`, once high, stays high with `out_data` unchanged until the cycle `out_ready` is high. `in_ready` is low whenever `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Sequencer accepts the offered word this cycle |
| in_word | input | 17 | Bit 16 command flag, bits 15:0 payload |
| out_valid | output | 1 | Result word available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 16 | Result word |
| pin_in | input | 8 | Sampled pin levels |
| pin_wr_valid | output | 1 | Pin level update strobe |
| pin_wr_data | output | 8 | New pin levels |
| pin_dir_valid | output | 1 | Pin direction update strobe |
| pin_dir_data | output | 8 | New pin directions |
| per_valid | output | 1 | Peripheral transfer offered |
| per_ready | input | 1 | Peripheral accepts the transfer |
| per_read | output | 1 | Transfer returns a result |
| per_data | output | 16 | Transfer payload |
| per_rdata | input | 16 | Peripheral result, valid in the handshake cycle |
| pwm_on_valid | output | 1 | High-time update strobe |
| pwm_off_valid | output | 1 | Low-time update strobe |
| pwm_period | output | 16 | Period value for the strobe |
| la_start | output | 1 | Capture start strobe |
| la_stop | output | 1 | Capture stop strobe |
| halted | output | 1 | Sequencer halted |
| resume | input | 1 | Leave the halted state |
| pin_oe | output | 8 | Pin output enables (entry 0) |
| pin_od | output | 8 | Pin open-drain enables (entry 1) |
| pullup_en | output | 1 | Pull-up enable (entry 2 bit 0) |

## Verification
The assertions assume that the peripheral side never withdraws `per_ready`'s meaning: a transfer counts as complete in any cycle where both `per_valid` and `per_ready` are high. They also assume that `in_word` is sampled only in the cycle it is accepted. The stimulus holds each word steady from its offer until acceptance. It drives `per_ready`, `out_ready` and `pin_in` from a free-running pseudo-random sequence, so stalls and held results occur at arbitrary points. It pulses `resume` only while the sequencer is halted.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

  typedef enum logic [3:0] {
    M_IDLE,
    M_PIN_WR,
    M_PIN_RD,
    M_PIN_DIR,
    M_PER_WR,
    M_PER_RD,
    M_DELAY,
    M_PWM_ON,
    M_PWM_OFF,
    M_PTR,
    M_REG_WR,
    M_REG_RD
  } mode_e;

  typedef enum logic [2:0] {
    S_RUN,
    S_PER,
    S_BURST,
    S_HALT
  } state_e;

  localparam logic [7:0] OP_PIN_WR  = 8'h00;
  localparam logic [7:0] OP_PIN_RD  = 8'h01;
  localparam logic [7:0] OP_PIN_DIR = 8'h02;
  localparam logic [7:0] OP_PER_WR  = 8'h03;
  localparam logic [7:0] OP_PER_RD  = 8'h04;
  localparam logic [7:0] OP_DELAY   = 8'h05;
  localparam logic [7:0] OP_PWM_ON  = 8'h06;
  localparam logic [7:0] OP_PWM_OFF = 8'h07;
  localparam logic [7:0] OP_CAP_GO  = 8'h09;
  localparam logic [7:0] OP_CAP_END = 8'h0A;
  localparam logic [7:0] OP_PTR     = 8'h0B;
  localparam logic [7:0] OP_REG_WR  = 8'h0C;
  localparam logic [7:0] OP_REG_RD  = 8'h0D;
  localparam logic [7:0] OP_HALT    = 8'h0F;

endpackage

// File: rtl/cmdseq_decode.sv
module cmdseq_decode
  import cmdseq_pkg::*;
(
  input  logic [7:0] opcode,
  output mode_e      mode,
  output logic       cap_go,
  output logic       cap_end,
  output logic       halt_req
);

  always_comb begin
    mode     = M_IDLE;
    cap_go   = 1'b0;
    cap_end  = 1'b0;
    halt_req = 1'b0;
    case (opcode)
      OP_PIN_WR:  mode = M_PIN_WR;
      OP_PIN_RD:  mode = M_PIN_RD;
      OP_PIN_DIR: mode = M_PIN_DIR;
      OP_PER_WR:  mode = M_PER_WR;
      OP_PER_RD:  mode = M_PER_RD;
      OP_DELAY:   mode = M_DELAY;
      OP_PWM_ON:  mode = M_PWM_ON;
      OP_PWM_OFF: mode = M_PWM_OFF;
      OP_PTR:     mode = M_PTR;
      OP_REG_WR:  mode = M_REG_WR;
      OP_REG_RD:  mode = M_REG_RD;
      OP_CAP_GO:  cap_go = 1'b1;
      OP_CAP_END: cap_end = 1'b1;
      OP_HALT:    halt_req = 1'b1;
      default:    mode = M_IDLE;
    endcase
  end

  // R13: a word that is not a known opcode never raises more than one action
  always_comb begin
    a_one_action_r13: assert ($countones({cap_go, cap_end, halt_req}) <= 1);
  end

endmodule

// File: rtl/cmdseq_regfile.sv
module cmdseq_regfile #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int PINS   = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_load,
  input  logic [PTR_W-1:0]  ptr_val,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_step,
  output logic [DATA_W-1:0] rd_data,
  output logic [PINS-1:0]   cfg_oe,
  output logic [PINS-1:0]   cfg_od,
  output logic              cfg_pull
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  ptr_nxt;

  assign ptr_nxt = (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ptr_load) begin
      ptr <= ptr_val;
    end else if (wr_en || rd_step) begin
      ptr <= ptr_nxt;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[gi] <= '0;
      end else if (wr_en && ptr == PTR_W'(gi)) begin
        mem[gi] <= wr_data;
      end
    end
  end

  assign rd_data  = mem[ptr];
  assign cfg_oe   = mem[0][PINS-1:0];
  assign cfg_od   = mem[1][PINS-1:0];
  assign cfg_pull = mem[2][0];

  // R8: a write lands at the pointer it was issued against
  p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(ptr)] == $past(wr_data));

  // R8: the pointer steps by one and wraps after the last entry
  p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ptr_load && $past(rst_n)) |=>
      ptr == (($past(ptr) == PTR_W'(DEPTH - 1)) ? '0 : $past(ptr) + 1'b1));

endmodule

// File: rtl/cmdseq_timer.sv
module cmdseq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         busy
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= len;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);

  // R5: a wait is never restarted while one is running
  p_no_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load);

  // R5: a running wait counts down by exactly one per cycle
  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top
  import cmdseq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PINS   = 8,
  parameter int REGS   = 16,
  localparam int WORD_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic [PINS-1:0]   pin_in,
  output logic              pin_wr_valid,
  output logic [PINS-1:0]   pin_wr_data,
  output logic              pin_dir_valid,
  output logic [PINS-1:0]   pin_dir_data,
  output logic              per_valid,
  input  logic              per_ready,
  output logic              per_read,
  output logic [DATA_W-1:0] per_data,
  input  logic [DATA_W-1:0] per_rdata,
  output logic              pwm_on_valid,
  output logic              pwm_off_valid,
  output logic [DATA_W-1:0] pwm_period,
  output logic              la_start,
  output logic              la_stop,
  output logic              halted,
  input  logic              resume,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   pin_od,
  output logic              pullup_en
);

  localparam int PTR_W = $clog2(REGS);
  localparam int CNT_W = PTR_W + 1;

  state_e            state;
  mode_e             mode;
  mode_e             dec_mode;
  logic              dec_go, dec_end, dec_halt;
  logic              accept, is_cmd;
  logic [DATA_W-1:0] dword;
  logic              wait_busy;
  logic              slot_free;
  logic [CNT_W-1:0]  burst_left;
  logic [DATA_W-1:0] rf_rd;
  logic              rf_ptr_load, rf_wr, rf_step, tm_load;

  assign is_cmd    = in_word[WORD_W-1];
  assign dword     = in_word[DATA_W-1:0];
  assign in_ready  = (state == S_RUN) && !wait_busy && !out_valid;
  assign accept    = in_valid && in_ready;
  assign slot_free = !out_valid || out_ready;
  assign halted    = (state == S_HALT);

  assign rf_ptr_load = accept && !is_cmd && (mode == M_PTR);
  assign rf_wr       = accept && !is_cmd && (mode == M_REG_WR);
  assign rf_step     = (state == S_BURST) && slot_free;
  assign tm_load     = accept && !is_cmd && (mode == M_DELAY);

  cmdseq_decode u_dec (
    .opcode   (in_word[7:0]),
    .mode     (dec_mode),
    .cap_go   (dec_go),
    .cap_end  (dec_end),
    .halt_req (dec_halt)
  );

  cmdseq_regfile #(.DATA_W(DATA_W), .DEPTH(REGS), .PINS(PINS)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_load (rf_ptr_load),
    .ptr_val  (dword[PTR_W-1:0]),
    .wr_en    (rf_wr),
    .wr_data  (dword),
    .rd_step  (rf_step),
    .rd_data  (rf_rd),
    .cfg_oe   (pin_oe),
    .cfg_od   (pin_od),
    .cfg_pull (pullup_en)
  );

  cmdseq_timer #(.W(DATA_W)) u_tm (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tm_load),
    .len   (dword),
    .busy  (wait_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_RUN;
      mode          <= M_IDLE;
      out_valid     <= 1'b0;
      out_data      <= '0;
      per_valid     <= 1'b0;
      per_read      <= 1'b0;
      per_data      <= '0;
      burst_left    <= '0;
      pin_wr_valid  <= 1'b0;
      pin_wr_data   <= '0;
      pin_dir_valid <= 1'b0;
      pin_dir_data  <= '0;
      pwm_on_valid  <= 1'b0;
      pwm_off_valid <= 1'b0;
      pwm_period    <= '0;
      la_start      <= 1'b0;
      la_stop       <= 1'b0;
    end else begin
      pin_wr_valid  <= 1'b0;
      pin_dir_valid <= 1'b0;
      pwm_on_valid  <= 1'b0;
      pwm_off_valid <= 1'b0;
      la_start      <= 1'b0;
      la_stop       <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;

      case (state)
        S_RUN: begin
          if (accept && is_cmd) begin
            mode     <= dec_mode;
            la_start <= dec_go;
            la_stop  <= dec_end;
            if (dec_halt) state <= S_HALT;
          end else if (accept) begin
            case (mode)
              M_PIN_WR: begin
                pin_wr_valid <= 1'b1;
                pin_wr_data  <= dword[PINS-1:0];
              end
              M_PIN_DIR: begin
                pin_dir_valid <= 1'b1;
                pin_dir_data  <= dword[PINS-1:0];
              end
              M_PIN_RD: begin
                out_valid <= 1'b1;
                out_data  <= {{(DATA_W-PINS){1'b0}}, pin_in};
              end
              M_PER_WR, M_PER_RD: begin
                per_valid <= 1'b1;
                per_read  <= (mode == M_PER_RD);
                per_data  <= dword;
                state     <= S_PER;
              end
              M_PWM_ON: begin
                pwm_on_valid <= 1'b1;
                pwm_period   <= dword;
              end
              M_PWM_OFF: begin
                pwm_off_valid <= 1'b1;
                pwm_period    <= dword;
              end
              M_REG_RD: begin
                if (dword[CNT_W-1:0] != '0) begin
                  burst_left <= dword[CNT_W-1:0];
                  state      <= S_BURST;
                end
              end
              default: ;
            endcase
          end
        end
        S_PER: begin
          if (per_ready) begin
            per_valid <= 1'b0;
            state     <= S_RUN;
            if (per_read) begin
              out_valid <= 1'b1;
              out_data  <= per_rdata;
            end
          end
        end
        S_BURST: begin
          if (slot_free) begin
            out_valid  <= 1'b1;
            out_data   <= rf_rd;
            burst_left <= burst_left - 1'b1;
            if (burst_left == CNT_W'(1)) state <= S_RUN;
          end
        end
        S_HALT: begin
          if (resume) state <= S_RUN;
        end
        default: state <= S_RUN;
      endcase
    end
  end

  // R14: a held result does not move until it is taken
  p_out_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));

  // R14: no word is taken while a result waits
  p_no_take_with_result_r14: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R4: an open transfer keeps its payload until accepted
  p_per_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (per_valid && !per_ready) |=> per_valid && $stable(per_data) && $stable(per_read));

  // R4: a completed read transfer yields a result next cycle
  p_per_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (per_valid && per_ready && per_read) |=> out_valid && out_data == $past(per_rdata));

  // R12: nothing is consumed while halted
  p_halt_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !in_ready);

  // R2: side-effect strobes never overlap
  p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pin_wr_valid, pin_dir_valid, pwm_on_valid, pwm_off_valid, la_start, la_stop}));

endmodule

// File: tb/tb_cmdseq_top.sv
module tb_cmdseq_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [16:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic [7:0]  pin_in = 8'h00;
  logic        pin_wr_valid, pin_dir_valid;
  logic [7:0]  pin_wr_data, pin_dir_data;
  logic        per_valid, per_read;
  logic        per_ready = 1'b0;
  logic [15:0] per_data, per_rdata;
  logic        pwm_on_valid, pwm_off_valid;
  logic [15:0] pwm_period;
  logic        la_start, la_stop, halted;
  logic        resume = 1'b0;
  logic [7:0]  pin_oe, pin_od;
  logic        pullup_en;

  always #5 clk = ~clk;

  assign per_rdata = per_data ^ 16'h5A3C;

  cmdseq_top dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .pin_in(pin_in),
    .pin_wr_valid(pin_wr_valid), .pin_wr_data(pin_wr_data),
    .pin_dir_valid(pin_dir_valid), .pin_dir_data(pin_dir_data),
    .per_valid(per_valid), .per_ready(per_ready), .per_read(per_read),
    .per_data(per_data), .per_rdata(per_rdata),
    .pwm_on_valid(pwm_on_valid), .pwm_off_valid(pwm_off_valid), .pwm_period(pwm_period),
    .la_start(la_start), .la_stop(la_stop),
    .halted(halted), .resume(resume),
    .pin_oe(pin_oe), .pin_od(pin_od), .pullup_en(pullup_en)
  );

  int checks = 0;
  int failures = 0;
  bit run_on = 1'b0;
  bit free_ready = 1'b1;

  // reference state
  int          m_mode = -1;
  int          m_ptr = 0;
  logic [15:0] m_regs [16];
  logic [7:0]  q_pinw [$];
  logic [7:0]  q_pind [$];
  logic [16:0] q_per [$];
  logic [16:0] q_pwm [$];
  logic [15:0] q_out [$];
  int exp_go = 0, exp_end = 0, got_go = 0, got_end = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input bit cmd, input logic [15:0] d);
    if (cmd) begin
      case (d[7:0])
        8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
        8'h0B, 8'h0C, 8'h0D: m_mode = int'(d[7:0]);
        8'h09: begin exp_go++; m_mode = -1; end
        8'h0A: begin exp_end++; m_mode = -1; end
        default: m_mode = -1;
      endcase
    end else begin
      case (m_mode)
        0: q_pinw.push_back(d[7:0]);
        1: q_out.push_back({8'h00, pin_in});
        2: q_pind.push_back(d[7:0]);
        3: q_per.push_back({1'b0, d});
        4: begin q_per.push_back({1'b1, d}); q_out.push_back(d ^ 16'h5A3C); end
        6: q_pwm.push_back({1'b0, d});
        7: q_pwm.push_back({1'b1, d});
        11: m_ptr = int'(d[3:0]);
        12: begin m_regs[m_ptr] = d; m_ptr = (m_ptr + 1) % 16; end
        13: for (int k = 0; k < int'(d[4:0]); k++) begin
              q_out.push_back(m_regs[m_ptr]);
              m_ptr = (m_ptr + 1) % 16;
            end
        default: ;
      endcase
    end
  endtask

  task automatic send(input bit cmd, input logic [15:0] d);
    @(posedge clk); #3;
    in_valid = 1'b1;
    in_word  = {cmd, d};
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    apply(cmd, d);
    #3 in_valid = 1'b0;
  endtask

  task automatic drain();
    forever begin
      @(negedge clk);
      if (q_out.size() == 0 && q_per.size() == 0 && !out_valid && !per_valid && in_ready) break;
    end
  endtask

  task automatic delay_case(input int n);
    int cnt;
    drain();
    send(1'b0, 16'(n));
    cnt = 0;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      cnt++;
    end
    chk(cnt == n, "R5 delay length", 32'(cnt), 32'(n));
  endtask

  // pseudo-random readiness and pin levels
  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    forever begin
      @(posedge clk); #3;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (free_ready) begin
        per_ready = lfsr[0] | lfsr[2];
        out_ready = lfsr[1] | lfsr[4];
      end else begin
        per_ready = 1'b1;
        out_ready = 1'b1;
      end
      pin_in = lfsr[15:8];
    end
  end

  // per-clock comparison with the reference
  always @(negedge clk) begin
    if (run_on && rst_n) begin
      if (pin_wr_valid) begin
        if (q_pinw.size() == 0) chk(1'b0, "R2 unexpected pin write", 32'(pin_wr_data), 32'hFFFF_FFFF);
        else begin chk(pin_wr_data == q_pinw[0], "R2 pin write value", 32'(pin_wr_data), 32'(q_pinw[0])); void'(q_pinw.pop_front()); end
      end
      if (pin_dir_valid) begin
        if (q_pind.size() == 0) chk(1'b0, "R2 unexpected pin direction", 32'(pin_dir_data), 32'hFFFF_FFFF);
        else begin chk(pin_dir_data == q_pind[0], "R2 pin direction value", 32'(pin_dir_data), 32'(q_pind[0])); void'(q_pind.pop_front()); end
      end
      if (per_valid && per_ready) begin
        if (q_per.size() == 0) chk(1'b0, "R4 unexpected transfer", 32'(per_data), 32'hFFFF_FFFF);
        else begin chk({per_read, per_data} == q_per[0], "R4 transfer", 32'({per_read, per_data}), 32'(q_per[0])); void'(q_per.pop_front()); end
      end
      if (out_valid && out_ready) begin
        if (q_out.size() == 0) chk(1'b0, "R14 unexpected result", 32'(out_data), 32'hFFFF_FFFF);
        else begin chk(out_data == q_out[0], "R3 R4 R9 result word", 32'(out_data), 32'(q_out[0])); void'(q_out.pop_front()); end
      end
      if (pwm_on_valid || pwm_off_valid) begin
        if (q_pwm.size() == 0) chk(1'b0, "R6 unexpected period", 32'(pwm_period), 32'hFFFF_FFFF);
        else begin chk({pwm_off_valid, pwm_period} == q_pwm[0], "R6 period update", 32'({pwm_off_valid, pwm_period}), 32'(q_pwm[0])); void'(q_pwm.pop_front()); end
      end
      if (la_start) got_go++;
      if (la_stop) got_end++;
      chk(pin_oe == m_regs[0][7:0] && pin_od == m_regs[1][7:0] && pullup_en == m_regs[2][0],
          "R10 config outputs", 32'({pullup_en, pin_od, pin_oe}),
          32'({m_regs[2][0], m_regs[1][7:0], m_regs[0][7:0]}));
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_regs[i] = '0;
    repeat (4) @(posedge clk);
    #3 rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid && !halted && !per_valid, "R1 reset state",
        32'({in_ready, out_valid, halted, per_valid}), 32'b1000);
    chk(pin_oe == 8'h00 && pin_od == 8'h00 && !pullup_en, "R10 reset config",
        32'({pullup_en, pin_od, pin_oe}), 32'h0);
    run_on = 1'b1;

    // R1: data before any command is discarded
    send(1'b0, 16'h00FF); send(1'b0, 16'h1234); send(1'b0, 16'h0003);

    // R2: persistent pin write and direction modes
    send(1'b1, 16'h0000);
    for (int i = 0; i < 5; i++) send(1'b0, 16'(16'hA500 + i * 37));
    send(1'b1, 16'h0002);
    for (int i = 0; i < 3; i++) send(1'b0, 16'(16'h0F0F >> i));

    // R3: pin sampling
    send(1'b1, 16'h0001);
    for (int i = 0; i < 6; i++) send(1'b0, 16'h0000);

    // R4: peripheral write then read
    send(1'b1, 16'h0003);
    for (int i = 0; i < 4; i++) send(1'b0, 16'(16'h1111 * (i + 1)));
    send(1'b1, 16'h0004);
    for (int i = 0; i < 4; i++) send(1'b0, 16'(16'hBEE0 + i));

    // R6: period updates
    send(1'b1, 16'h0006); send(1'b0, 16'd1000); send(1'b0, 16'd250);
    send(1'b1, 16'h0007); send(1'b0, 16'd3000);

    // R7 R8: pointer near the end, write across the wrap
    send(1'b1, 16'h000B); send(1'b0, 16'h00FE);
    send(1'b1, 16'h000C);
    for (int i = 0; i < 5; i++) send(1'b0, 16'(16'hC000 + i));
    // R8: full fill from zero
    send(1'b1, 16'h000B); send(1'b0, 16'h0000);
    send(1'b1, 16'h000C);
    for (int i = 0; i < 16; i++) send(1'b0, 16'(16'h0101 * i + 16'h0055));
    // R9: reads, including wrap and zero count
    send(1'b1, 16'h000D); send(1'b0, 16'h0010);
    send(1'b1, 16'h000B); send(1'b0, 16'h000E);
    send(1'b1, 16'h000D); send(1'b0, 16'h0003); send(1'b0, 16'h0000); send(1'b0, 16'h0002);
    drain();
    chk(q_out.size() == 0, "R9 all register words returned", 32'(q_out.size()), 32'h0);

    // R5: delays
    send(1'b1, 16'h0005);
    delay_case(0); delay_case(1); delay_case(7); delay_case(40);

    // R11: capture strobes and discard afterwards
    send(1'b1, 16'h0009); send(1'b0, 16'h0077);
    send(1'b1, 16'h000A); send(1'b0, 16'h0088);

    // R13: unknown opcodes discard data
    send(1'b1, 16'h000E); send(1'b0, 16'h00AA);
    send(1'b1, 16'h0008); send(1'b0, 16'h00BB);
    send(1'b1, 16'h013C); send(1'b0, 16'h00CC);

    // R12: halt and resume
    drain();
    send(1'b1, 16'h000F);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(halted && !in_ready, "R12 halted blocks input", 32'({halted, in_ready}), 32'b10);
    end
    @(posedge clk); #3 resume = 1'b1;
    @(posedge clk); #3 resume = 1'b0;
    @(negedge clk);
    chk(!halted && in_ready, "R12 resume", 32'({halted, in_ready}), 32'b01);
    send(1'b0, 16'h0099);
    send(1'b1, 16'h0000); send(1'b0, 16'h005A);

    // R1 R14: final drain with full readiness
    free_ready = 1'b0;
    drain();
    repeat (4) @(negedge clk);
    chk(q_pinw.size() == 0 && q_pind.size() == 0 && q_pwm.size() == 0,
        "R2 R6 all strobes seen", 32'(q_pinw.size() + q_pind.size() + q_pwm.size()), 32'h0);
    chk(got_go == exp_go && got_end == exp_end, "R11 capture strobe counts",
        32'({got_go[15:0], got_end[15:0]}), 32'({exp_go[15:0], exp_end[15:0]}));
    summary();
    $finish;
  end

endmodule